// File: doc/BRIEF.md
# Free-Running Timer with Watchdog Compare

This peripheral holds a 32-bit up-counter that advances by one on every clock cycle in which the `tick` enable is high. In normal use `tick` comes from a 1 MHz prescaler, so one second of timeout is 1,000,000 counts. Six compare channels each hold a match value. On the cycle after the counter steps onto a channel's match value, that channel's sticky status bit sets. The interrupt output is high whenever a set status bit has its enable bit set. Software can capture the counter into a snapshot register and then read it back, so the value it reads is consistent.

Compare channel 5 also serves as the watchdog. Software arms it by writing a match value equal to the current count plus the timeout in ticks. It keeps the system alive by rewriting that match further ahead before the count gets there. If the counter reaches the channel 5 match while both the channel 5 interrupt enable and the global watchdog enable are set, the block drives a reset output for a fixed number of clock cycles. If either enable is clear, that match produces no reset. Match values use modular 32-bit addition, so a deadline that wraps past zero is reached after the counter wraps.

The register port is synchronous. A write takes effect at the clock edge. Read data appears on `busRdata` one cycle after the read request and holds until the next read. Addresses are byte addresses decoded on 32-bit words:

| Address | Access | Contents |
|---------|--------|----------|
| 0x00 | read-only | live counter |
| 0x08 + 4·n, n = 0 to 5 | read/write | match value for channel n |
| 0x20 | read, write 1 to clear | status, bit n for channel n |
| 0x24 | read/write | interrupt enable, bit n for channel n |
| 0x28 | read/write | watchdog enable, bit 0 |
| 0x30 | write | capture trigger |
| 0x34 | read-only | captured counter |

Top module: `tick_watchdog_timer`

## Requirements
- R1: After reset, the counter, all match values, the status register, the interrupt enables, the watchdog enable and the captured counter read 0. `irqOut` and `wdtRstOut` are low.
- R2: The counter at 0x00 increases by exactly one at each clock edge where `tick` is 1, and holds its value at every other edge.
- R3: Each match channel n is read and written at byte address 0x08 + 4·n, with n from 0 to 5. Read data appears on `busRdata` at the first clock edge after the read request.
- R4: When the counter steps onto channel n's match value, status bit n at 0x20 is set at the next edge and stays set. Writing a 1 to bit n at 0x20 clears that bit.
- R5: `irqOut` is high exactly when some status bit n is set and interrupt-enable bit n at 0x24 is also set.
- R6: If channel 5 matches while interrupt-enable bit 5 is 1 and the watchdog enable (bit 0 at 0x28) is 1, `wdtRstOut` goes high at the next edge and stays high for RST_HOLD cycles (4 by default).
- R7: A channel 5 match does not raise `wdtRstOut` if either the watchdog enable or interrupt-enable bit 5 is 0. Status bit 5 still sets.
- R8: A write with bit 0 set to 0x30 copies the live counter into 0x34. That copy holds while the counter keeps running.
- R9: Writes to 0x00 and to 0x34 are ignored.
- R10: If channel 5's match is rewritten to a later value before the counter reaches the old one, the old deadline causes no reset and the new deadline does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rstN | input | 1 | active-low synchronous reset |
| tick | input | 1 | count enable from the prescaler |
| busSel | input | 1 | register access request |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | byte address |
| busWdata | input | 32 | write data |
| busRdata | output | 32 | read data, one cycle after the request |
| irqOut | output | 1 | OR of enabled status bits |
| wdtRstOut | output | 1 | watchdog reset, high for RST_HOLD cycles |

## Verification
The assertions assume that `tick` and the bus inputs are stable around the rising edge. They also assume that a status clear and a new match on the same bit are not requested in the same cycle. The bench drives every input on the falling edge, so inputs are settled before each rising edge. It issues each bus access as a single-cycle request with `tick` held low, so count values are known exactly. No scenario clears status while a match on that channel is due.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NUM_CH   = 6;
  localparam int WDT_CH   = 5;
  localparam int CNT_W    = 32;
  localparam int ADDR_W   = 8;
  localparam int CH_IDX_W = $clog2(NUM_CH);

  // word offsets (byte address / 4)
  localparam int W_COUNT  = 0;
  localparam int W_MATCH0 = 2;
  localparam int W_STATUS = 8;
  localparam int W_IEN    = 9;
  localparam int W_WDEN   = 10;
  localparam int W_LATCH  = 12;
  localparam int W_SNAP   = 13;

  typedef enum logic [2:0] {
    RD_ZERO, RD_COUNT, RD_MATCH, RD_STATUS, RD_IEN, RD_WDEN, RD_SNAP
  } rd_sel_e;

  typedef struct packed {
    logic [NUM_CH-1:0]   wrMatch;
    logic                wrIen;
    logic                wrWden;
    logic                wrStatus;
    logic                doLatch;
    logic                rdEn;
    rd_sel_e             rdSel;
    logic [CH_IDX_W-1:0] rdCh;
  } tmr_strobe_t;
endpackage

// File: rtl/tmr_control.sv
module tmr_control
  import tmr_pkg::*;
#(
  parameter int RST_HOLD = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              latchBit,
  input  logic              wdtFire,
  output tmr_strobe_t       strb,
  output logic              wdtRstOut
);
  localparam int HOLD_W = $clog2(RST_HOLD + 1);

  int wordIdx;
  logic wrReq, rdReq;
  logic [HOLD_W-1:0] holdCnt;

  assign wordIdx = int'(busAddr[ADDR_W-1:2]);
  assign wrReq   = busSel && busWr;
  assign rdReq   = busSel && !busWr;

  always_comb begin
    strb = '0;
    strb.rdEn = rdReq;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (wordIdx == W_MATCH0 + ch) begin
        strb.wrMatch[ch] = wrReq;
        strb.rdSel       = RD_MATCH;
        strb.rdCh        = CH_IDX_W'(ch);
      end
    end
    if (wordIdx == W_COUNT)  strb.rdSel = RD_COUNT;
    if (wordIdx == W_STATUS) begin strb.rdSel = RD_STATUS; strb.wrStatus = wrReq; end
    if (wordIdx == W_IEN)    begin strb.rdSel = RD_IEN;    strb.wrIen    = wrReq; end
    if (wordIdx == W_WDEN)   begin strb.rdSel = RD_WDEN;   strb.wrWden   = wrReq; end
    if (wordIdx == W_LATCH)  strb.doLatch = wrReq && latchBit;
    if (wordIdx == W_SNAP)   strb.rdSel = RD_SNAP;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                holdCnt <= '0;
    else if (wdtFire)         holdCnt <= HOLD_W'(RST_HOLD);
    else if (holdCnt != '0)   holdCnt <= holdCnt - 1'b1;
  end

  assign wdtRstOut = (holdCnt != '0);

  a_r6_fire_starts_reset: assert property (@(posedge clk) disable iff (!rstN)
    wdtFire |=> wdtRstOut);
  a_r6_no_spurious_reset: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wdtRstOut) |-> $past(wdtFire));
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic [CNT_W-1:0] busWdata,
  input  tmr_strobe_t      strb,
  output logic [CNT_W-1:0] rdData,
  output logic             irqOut,
  output logic             wdtFire
);
  logic [CNT_W-1:0]  count, snap;
  logic [CNT_W-1:0]  matchVal [NUM_CH];
  logic [NUM_CH-1:0] hit, status, ien, clrMask;
  logic              fresh, wden;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
      fresh <= 1'b0;
    end else begin
      if (tick) count <= count + CNT_W'(1);
      fresh <= tick;
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    always_ff @(posedge clk) begin
      if (!rstN)                 matchVal[ch] <= '0;
      else if (strb.wrMatch[ch]) matchVal[ch] <= busWdata;
    end
    assign hit[ch] = fresh && (count == matchVal[ch]);
  end

  assign clrMask = strb.wrStatus ? busWdata[NUM_CH-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      status <= '0;
      ien    <= '0;
      wden   <= 1'b0;
      snap   <= '0;
    end else begin
      status <= (status & ~clrMask) | hit;
      if (strb.wrIen)   ien  <= busWdata[NUM_CH-1:0];
      if (strb.wrWden)  wden <= busWdata[0];
      if (strb.doLatch) snap <= count;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else if (strb.rdEn) begin
      unique case (strb.rdSel)
        RD_COUNT:  rdData <= count;
        RD_MATCH:  rdData <= matchVal[strb.rdCh];
        RD_STATUS: rdData <= CNT_W'(status);
        RD_IEN:    rdData <= CNT_W'(ien);
        RD_WDEN:   rdData <= CNT_W'(wden);
        RD_SNAP:   rdData <= snap;
        default:   rdData <= '0;
      endcase
    end
  end

  assign irqOut  = |(status & ien);
  assign wdtFire = hit[WDT_CH] && ien[WDT_CH] && wden;

  a_r2_count_step: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> count == $past(count) + CNT_W'(1));
  a_r2_count_hold: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> $stable(count));
  a_r4_status_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrStatus |=> ((status & $past(status)) == $past(status)));
  a_r8_snapshot_copy: assert property (@(posedge clk) disable iff (!rstN)
    strb.doLatch |=> snap == $past(count));
  a_r9_snapshot_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.doLatch |=> $stable(snap));
endmodule

// File: rtl/tick_watchdog_timer.sv
module tick_watchdog_timer
  import tmr_pkg::*;
#(
  parameter int RST_HOLD = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CNT_W-1:0]  busWdata,
  output logic [CNT_W-1:0]  busRdata,
  output logic              irqOut,
  output logic              wdtRstOut
);
  tmr_strobe_t strb;
  logic        wdtFire;

  tmr_control #(.RST_HOLD(RST_HOLD)) u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .latchBit(busWdata[0]), .wdtFire(wdtFire), .strb(strb), .wdtRstOut(wdtRstOut)
  );

  tmr_datapath u_dp (
    .clk(clk), .rstN(rstN), .tick(tick), .busWdata(busWdata), .strb(strb),
    .rdData(busRdata), .irqOut(irqOut), .wdtFire(wdtFire)
  );
endmodule

// File: tb/tick_watchdog_timer_bench.sv
module tick_watchdog_timer_bench;
  localparam int HOLD = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut, wdtRstOut;

  int checks = 0;
  int errors = 0;
  int rstCycles = 0;
  logic [31:0] expCount = '0;

  always #2 clk = ~clk;

  tick_watchdog_timer #(.RST_HOLD(HOLD)) u_tick_watchdog_timer (
    .clk(clk), .rstN(rstN), .tick(tick), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .irqOut(irqOut), .wdtRstOut(wdtRstOut)
  );

  always @(negedge clk) if (rstN && wdtRstOut) rstCycles++;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic [7:0] addr, logic [31:0] data);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = addr; busWdata = data;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(logic [7:0] addr, output logic [31:0] data);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = addr;
    @(posedge clk); #1;
    data = busRdata;
    busSel = 1'b0;
  endtask

  task automatic tickN(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(posedge clk);
    end
    @(negedge clk); tick = 1'b0;
    expCount += 32'(n);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic testReset();
    logic [31:0] d;
    busRead(8'h00, d); chk("R1 count", d, 0);
    busRead(8'h14, d); chk("R1 match3", d, 0);
    busRead(8'h24, d); chk("R1 ien", d, 0);
    busRead(8'h28, d); chk("R1 wden", d, 0);
    busRead(8'h34, d); chk("R1 snap", d, 0);
    chk("R1 irq", irqOut, 0);
    chk("R1 wdtRst", wdtRstOut, 0);
  endtask

  task automatic testCounter();
    logic [31:0] d;
    tickN(5);
    busRead(8'h00, d); chk("R2 after 5 ticks", d, expCount);
    idle(6);
    busRead(8'h00, d); chk("R2 holds without tick", d, expCount);
  endtask

  task automatic testMatchRw();
    logic [31:0] d;
    for (int n = 0; n < 6; n++) busWrite(8'(8 + 4 * n), 32'hA000_0100 + 32'(n));
    for (int n = 0; n < 6; n++) begin
      busRead(8'(8 + 4 * n), d);
      chk("R3 match readback", d, 32'hA000_0100 + 32'(n));
    end
    busRead(8'h04, d); chk("R3 unmapped word", d, 0);
  endtask

  task automatic testStatusIrq();
    logic [31:0] d;
    busWrite(8'h10, expCount + 3);
    tickN(3);
    idle(1);
    busRead(8'h20, d); chk("R4 status bit2 set", d, 32'h4);
    chk("R5 irq off while disabled", irqOut, 0);
    tickN(2);
    busRead(8'h20, d); chk("R4 status sticky", d, 32'h4);
    busWrite(8'h24, 32'h4);
    #1 chk("R5 irq on when enabled", irqOut, 1);
    busWrite(8'h20, 32'h4);
    #1 chk("R5 irq off after clear", irqOut, 0);
    busRead(8'h20, d); chk("R4 status cleared", d, 0);
    busWrite(8'h24, 32'h0);
  endtask

  task automatic testWdtFire();
    logic [31:0] d;
    busWrite(8'h24, 32'h20);
    busWrite(8'h28, 32'h1);
    busWrite(8'h1C, expCount + 4);
    rstCycles = 0;
    tickN(4);
    chk("R6 reset not before match edge", wdtRstOut, 0);
    @(posedge clk); #1;
    chk("R6 reset high after match", wdtRstOut, 1);
    idle(10);
    chk("R6 reset length", 32'(rstCycles), HOLD);
    chk("R5 irq from channel 5", irqOut, 1);
    busWrite(8'h20, 32'h20);
    busRead(8'h20, d); chk("R4 ch5 cleared", d, 0);
  endtask

  task automatic testWdtGated();
    logic [31:0] d;
    busWrite(8'h28, 32'h0);
    busWrite(8'h1C, expCount + 2);
    rstCycles = 0;
    tickN(2); idle(8);
    chk("R7 no reset with wden 0", 32'(rstCycles), 0);
    busRead(8'h20, d); chk("R7 status still set", d, 32'h20);
    busWrite(8'h20, 32'h20);
    busWrite(8'h28, 32'h1);
    busWrite(8'h24, 32'h0);
    busWrite(8'h1C, expCount + 2);
    tickN(2); idle(8);
    chk("R7 no reset with ien5 0", 32'(rstCycles), 0);
    busWrite(8'h20, 32'h20);
  endtask

  task automatic testLatch();
    logic [31:0] d, snapExp;
    tickN(7);
    snapExp = expCount;
    busWrite(8'h30, 32'h1);
    tickN(3);
    busRead(8'h34, d); chk("R8 snapshot value", d, snapExp);
    busWrite(8'h30, 32'h0);
    busRead(8'h34, d); chk("R8 write of 0 no capture", d, snapExp);
    busWrite(8'h34, 32'hDEAD_BEEF);
    busRead(8'h34, d); chk("R9 snapshot write ignored", d, snapExp);
    busWrite(8'h00, 32'hDEAD_BEEF);
    busRead(8'h00, d); chk("R9 counter write ignored", d, expCount);
  endtask

  task automatic testKeepalive();
    busWrite(8'h24, 32'h20);
    busWrite(8'h28, 32'h1);
    busWrite(8'h1C, expCount + 3);
    rstCycles = 0;
    tickN(2);
    busWrite(8'h1C, expCount + 4);
    tickN(2); idle(6);
    chk("R10 old deadline passed silently", 32'(rstCycles), 0);
    tickN(2); idle(8);
    chk("R10 new deadline resets", 32'(rstCycles), HOLD);
    busWrite(8'h28, 32'h0);
    busWrite(8'h24, 32'h0);
    busWrite(8'h20, 32'h3F);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    idle(1);
    testReset();
    testCounter();
    testMatchRw();
    testStatusIrq();
    testWdtFire();
    testWdtGated();
    testLatch();
    testKeepalive();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule